// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit IEEE 754 single-precision numbers. It returns the rounded product together with four exception flags: invalid, overflow, underflow and inexact. A caller pulses `start` with both operands on the same cycle. The product and its flags appear a fixed three clock cycles later, marked by a one-cycle `resValid` pulse. A new pair may be issued on every cycle, so several products can be in flight at once. The result and the flags hold their values until the next completion.

Inside, the block works in three stages:

- It captures the operands.
- It unpacks the sign, exponent and fraction of each operand. It sorts out NaN, infinity and zero operands, and it multiplies the 24-bit significands.
- It normalizes the product, rounds it to nearest with ties to even, checks the rounded exponent against the finite range, and packs the result.

Operands with a zero exponent field (zeros and subnormals) are treated as signed zero.

Top module: `fpm_mul_top`

## Requirements
- R1: Each `start` sampled high at a rising clock edge produces exactly one `resValid` pulse, high for the cycle that follows the third rising edge counted from that edge. Starts on consecutive cycles give results on consecutive cycles, in issue order.
- R2: For finite nonzero operands whose result is in range, the result sign is the XOR of the operand signs. The biased exponent is eA + eB − 127, plus one when the significand product is 2 or more. The fraction is the normalized significand product.
- R3: Rounding is to nearest, ties to even. It uses the guard bit (first discarded bit), the round bit (second discarded bit) and the sticky bit (OR of all lower discarded bits). A carry out of rounding increments the exponent. The inexact flag (field bit 0 of the flag nibble {invalid, overflow, underflow, inexact}) is set when any discarded bit is nonzero.
- R4: If the rounded biased exponent is 255 or more, the result is a correctly signed infinity (exponent field 0xFF, fraction 0), and overflow and inexact are both set. The largest finite value times 1.0 raises no flag.
- R5: If the rounded biased exponent is 0 or less, the result is a correctly signed zero, and underflow and inexact are both set. The smallest normal number 0x00800000 times 1.0 returns itself and raises no flag.
- R6: A NaN operand (exponent field 0xFF with a nonzero fraction, signaling or quiet, either sign) gives 0x7FC00000, with only the invalid flag set.
- R7: Zero times infinity, in either order and with any signs, gives 0x7FC00000 with only the invalid flag set. A subnormal counts as zero here.
- R8: Infinity times a nonzero finite value or infinity gives infinity with the XOR sign and raises no flag. Overflow is not raised.
- R9: Zero or subnormal times a finite value gives zero with the XOR sign and raises no flag.
- R10: While reset is asserted, `resValid`, `result` and all four flags are 0. A product in flight when reset is asserted never produces a `resValid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Issue a multiplication of `opA` and `opB` |
| opA | input | 32 | First operand, single-precision |
| opB | input | 32 | Second operand, single-precision |
| resValid | output | 1 | One-cycle pulse, three cycles after `start` |
| result | output | 32 | Rounded single-precision product |
| flagInvalid | output | 1 | Invalid operation (NaN operand or zero times infinity) |
| flagOverflow | output | 1 | Rounded result above the finite range |
| flagUnderflow | output | 1 | Rounded result tiny and flushed to zero |
| flagInexact | output | 1 | Result differs from the exact product |

## Verification
An exponent or sticky bit captured wrongly in the middle stage shows up on `result` or on the flags at the very next `resValid` pulse, three cycles after the start that carried it. Each such fault is caught on that same completion. A slip in the valid pipeline shows up as a pulse one cycle early or late, or as a missing pulse. That is visible at once against the start that caused it, both for isolated issues and for back-to-back issues. Rounding faults show only on a few operand pairs, so the vectors include ties with an odd last bit and with an even last bit, sticky-only residues, and the exponents at each edge of the finite range.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = 23;
  localparam int WORD_W   = 1 + EXP_W + FRAC_W;
  localparam int SIG_W    = FRAC_W + 1;
  localparam int PROD_W   = 2 * SIG_W;
  localparam int ESUM_W   = EXP_W + 2;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_ONES = (1 << EXP_W) - 1;
  localparam int LATENCY  = 3;

  // control-to-datapath strobes, one per pipeline stage
  typedef struct packed {
    logic load;
    logic mulEn;
    logic rndEn;
  } fpmStrobe_t;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } fpmFlags_t;

  // state carried from the multiply stage to the rounding stage
  typedef struct packed {
    logic                     sign;
    logic                     invalid;
    logic                     infRes;
    logic                     zeroRes;
    logic signed [ESUM_W-1:0] expSum;
    logic [PROD_W-1:0]        prod;
  } fpmProdStage_t;

  function automatic logic [WORD_W-1:0] qnanWord();
    return {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] infWord(input logic sgn);
    return {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction
endpackage

// File: rtl/fpm_mul_unpack.sv
module fpm_mul_unpack
  import fpm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              sign,
  output logic [EXP_W-1:0]  expField,
  output logic [SIG_W-1:0]  sig,
  output logic              isZero,
  output logic              isInf,
  output logic              isNan
);
  logic [FRAC_W-1:0] fracField;
  logic              expAllOnes;

  always_comb begin
    sign       = word[WORD_W-1];
    expField   = word[WORD_W-2 -: EXP_W];
    fracField  = word[FRAC_W-1:0];
    expAllOnes = &expField;
    // zero exponent field: true zero or subnormal, both flushed to zero
    isZero     = (expField == '0);
    isInf      = expAllOnes && (fracField == '0);
    isNan      = expAllOnes && (fracField != '0);
    sig        = isZero ? '0 : {1'b1, fracField};
  end
endmodule

// File: rtl/fpm_mul_ctrl.sv
module fpm_mul_ctrl
  import fpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output fpmStrobe_t strobe,
  output logic       done
);
  logic [LATENCY-1:0] stageVld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageVld <= '0;
    else       stageVld <= {stageVld[LATENCY-2:0], start};
  end

  always_comb begin
    strobe.load  = start;
    strobe.mulEn = stageVld[0];
    strobe.rndEn = stageVld[1];
    done         = stageVld[LATENCY-1];
  end
endmodule

// File: rtl/fpm_mul_dp.sv
module fpm_mul_dp
  import fpm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fpmStrobe_t        strobe,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] result,
  output fpmFlags_t         flags
);
  localparam logic signed [ESUM_W-1:0] BIAS_S    = ESUM_W'(BIAS);
  localparam logic signed [ESUM_W-1:0] EXP_SAT_S = ESUM_W'(EXP_ONES);

  // ---------------- stage 1: operand capture ----------------
  logic [WORD_W-1:0] opReg [2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg[0] <= '0;
      opReg[1] <= '0;
    end else if (strobe.load) begin
      opReg[0] <= opA;
      opReg[1] <= opB;
    end
  end

  // ---------------- stage 2: classify and multiply ----------------
  logic             opSign [2];
  logic [EXP_W-1:0] opExp  [2];
  logic [SIG_W-1:0] opSig  [2];
  logic             opZero [2];
  logic             opInf  [2];
  logic             opNan  [2];

  for (genvar i = 0; i < 2; i++) begin : g_unpack
    fpm_mul_unpack u_unpack (
      .word     (opReg[i]),
      .sign     (opSign[i]),
      .expField (opExp[i]),
      .sig      (opSig[i]),
      .isZero   (opZero[i]),
      .isInf    (opInf[i]),
      .isNan    (opNan[i])
    );
  end

  fpmProdStage_t prodNext, prodReg;

  always_comb begin
    prodNext.sign    = opSign[0] ^ opSign[1];
    prodNext.invalid = opNan[0] || opNan[1] ||
                       (opZero[0] && opInf[1]) || (opInf[0] && opZero[1]);
    prodNext.infRes  = (opInf[0] || opInf[1]) && !prodNext.invalid;
    prodNext.zeroRes = (opZero[0] || opZero[1]) && !prodNext.invalid;
    prodNext.expSum  = $signed({2'b00, opExp[0]}) + $signed({2'b00, opExp[1]}) - BIAS_S;
    prodNext.prod    = {{SIG_W{1'b0}}, opSig[0]} * {{SIG_W{1'b0}}, opSig[1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             prodReg <= '0;
    else if (strobe.mulEn) prodReg <= prodNext;
  end

  // ---------------- stage 3: normalize, round, pack ----------------
  logic                     topBit;
  logic [PROD_W-2:0]        normProd;
  logic [FRAC_W-1:0]        mantKeep;
  logic                     guardBit, roundBit, stickyBit, roundUp;
  logic [FRAC_W+1:0]        rounded;
  logic                     rndCarry;
  logic [FRAC_W-1:0]        finalFrac;
  logic signed [ESUM_W-1:0] expInc, expFinal;
  logic [WORD_W-1:0]        resNext;
  fpmFlags_t                flagsNext;

  always_comb begin
    topBit    = prodReg.prod[PROD_W-1];
    // left-align so the leading one sits just above normProd's MSB
    normProd  = topBit ? prodReg.prod[PROD_W-2:0] : {prodReg.prod[PROD_W-3:0], 1'b0};
    mantKeep  = normProd[PROD_W-2 -: FRAC_W];
    guardBit  = normProd[PROD_W-2-FRAC_W];
    roundBit  = normProd[PROD_W-3-FRAC_W];
    stickyBit = |normProd[PROD_W-4-FRAC_W:0];
    roundUp   = guardBit && (roundBit || stickyBit || mantKeep[0]);
    rounded   = {2'b01, mantKeep} + (FRAC_W+2)'(roundUp);
    rndCarry  = rounded[FRAC_W+1];
    finalFrac = rndCarry ? rounded[FRAC_W:1] : rounded[FRAC_W-1:0];
    expInc    = ESUM_W'(topBit) + ESUM_W'(rndCarry);
    expFinal  = prodReg.expSum + expInc;

    flagsNext = '0;
    if (prodReg.invalid) begin
      resNext           = qnanWord();
      flagsNext.invalid = 1'b1;
    end else if (prodReg.infRes) begin
      resNext = infWord(prodReg.sign);
    end else if (prodReg.zeroRes) begin
      resNext = {prodReg.sign, {(WORD_W-1){1'b0}}};
    end else if (expFinal >= EXP_SAT_S) begin
      resNext            = infWord(prodReg.sign);
      flagsNext.overflow = 1'b1;
      flagsNext.inexact  = 1'b1;
    end else if (expFinal <= $signed(ESUM_W'(0))) begin
      resNext             = {prodReg.sign, {(WORD_W-1){1'b0}}};
      flagsNext.underflow = 1'b1;
      flagsNext.inexact   = 1'b1;
    end else begin
      resNext           = {prodReg.sign, expFinal[EXP_W-1:0], finalFrac};
      flagsNext.inexact = guardBit || roundBit || stickyBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      flags  <= '0;
    end else if (strobe.rndEn) begin
      result <= resNext;
      flags  <= flagsNext;
    end
  end
endmodule

// File: rtl/fpm_mul_top.sv
module fpm_mul_top
  import fpm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              resValid,
  output logic [WORD_W-1:0] result,
  output logic              flagInvalid,
  output logic              flagOverflow,
  output logic              flagUnderflow,
  output logic              flagInexact
);
  fpmStrobe_t strobe;
  fpmFlags_t  flags;

  fpm_mul_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .done   (resValid)
  );

  fpm_mul_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .result (result),
    .flags  (flags)
  );

  assign flagInvalid   = flags.invalid;
  assign flagOverflow  = flags.overflow;
  assign flagUnderflow = flags.underflow;
  assign flagInexact   = flags.inexact;
endmodule

// File: rtl/fpm_mul_chk.sv
module fpm_mul_chk
  import fpm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [WORD_W-1:0] opA,
  input logic [WORD_W-1:0] opB,
  input logic              resValid,
  input logic [WORD_W-1:0] result,
  input logic              flagInvalid,
  input logic              flagOverflow,
  input logic              flagUnderflow,
  input logic              flagInexact
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  // edges seen since reset release, saturating at the pipeline depth
  logic [CNT_W-1:0] sinceRst;
  logic             histFull;
  logic             signIn;
  logic             resIsNan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != CNT_W'(LATENCY)) sinceRst <= sinceRst + 1'b1;
  end

  assign histFull = (sinceRst == CNT_W'(LATENCY));
  assign signIn   = opA[WORD_W-1] ^ opB[WORD_W-1];
  assign resIsNan = (&result[WORD_W-2 -: EXP_W]) && (result[FRAC_W-1:0] != '0);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    histFull |-> (resValid == $past(start, 3))); // R1

  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rstN)
    (histFull && resValid && !flagInvalid) |-> (result[WORD_W-1] == $past(signIn, 3))); // R2

  AST_OVF_TO_INF: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && flagOverflow) |-> (result[WORD_W-2:0] == infWord(1'b0) && flagInexact)); // R4

  AST_OVF_UNF_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(flagOverflow && flagUnderflow)); // R4

  AST_UNF_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && flagUnderflow) |-> (result[WORD_W-2:0] == '0 && flagInexact)); // R5

  AST_INVALID_QNAN: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && flagInvalid) |->
      (result == qnanWord() && !flagOverflow && !flagUnderflow && !flagInexact)); // R6

  AST_NAN_NEEDS_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resIsNan) |-> flagInvalid); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (!resValid && result == '0 && !flagInvalid && !flagOverflow
               && !flagUnderflow && !flagInexact)); // R10
endmodule

bind fpm_mul_top fpm_mul_chk chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .start         (start),
  .opA           (opA),
  .opB           (opB),
  .resValid      (resValid),
  .result        (result),
  .flagInvalid   (flagInvalid),
  .flagOverflow  (flagOverflow),
  .flagUnderflow (flagUnderflow),
  .flagInexact   (flagInexact)
);

// File: tb/fpm_mul_top_tb_top.sv
module fpm_mul_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        resValid;
  logic [31:0] result;
  logic        flagInvalid, flagOverflow, flagUnderflow, flagInexact;

  int checkCount = 0;
  int errCount   = 0;

  always #10 clk = ~clk; // 50 MHz

  fpm_mul_top dut_i (
    .clk           (clk),
    .rstN          (rstN),
    .start         (start),
    .opA           (opA),
    .opB           (opB),
    .resValid      (resValid),
    .result        (result),
    .flagInvalid   (flagInvalid),
    .flagOverflow  (flagOverflow),
    .flagUnderflow (flagUnderflow),
    .flagInexact   (flagInexact)
  );

  // vector layout: {req[3:0], opA, opB, expected result, flags {inv,ovf,unf,inx}}
  localparam int NVEC = 28;
  localparam logic [103:0] VEC [NVEC] = '{
    {4'd2, 32'h3F800000, 32'h3F800000, 32'h3F800000, 4'h0}, // R2 1*1
    {4'd2, 32'h40000000, 32'h40400000, 32'h40C00000, 4'h0}, // R2 2*3
    {4'd2, 32'hBFC00000, 32'h40000000, 32'hC0400000, 4'h0}, // R2 -1.5*2
    {4'd2, 32'hC0000000, 32'hC0400000, 32'h40C00000, 4'h0}, // R2 -2*-3
    {4'd3, 32'h3F800001, 32'h3F800001, 32'h3F800002, 4'h1}, // R3 sticky only
    {4'd3, 32'h3F800001, 32'h3FC00000, 32'h3FC00002, 4'h1}, // R3 tie, odd lsb, up
    {4'd3, 32'h3F800003, 32'h3FC00000, 32'h3FC00004, 4'h1}, // R3 tie, even lsb, stays
    {4'd3, 32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE, 4'h1}, // R3 product >= 2
    {4'd4, 32'h7F000000, 32'h40000000, 32'h7F800000, 4'h5}, // R4
    {4'd4, 32'hFF000000, 32'h40000000, 32'hFF800000, 4'h5}, // R4 negative
    {4'd4, 32'h7F000000, 32'h7F000000, 32'h7F800000, 4'h5}, // R4 far out
    {4'd4, 32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 4'h0}, // R4 boundary, max finite
    {4'd5, 32'h00800000, 32'h3F000000, 32'h00000000, 4'h3}, // R5
    {4'd5, 32'h80800000, 32'h3F000000, 32'h80000000, 4'h3}, // R5 negative
    {4'd5, 32'h00800000, 32'h3F800000, 32'h00800000, 4'h0}, // R5 boundary, min normal
    {4'd6, 32'h7FC00000, 32'h3F800000, 32'h7FC00000, 4'h8}, // R6 quiet NaN
    {4'd6, 32'h7F800001, 32'h40000000, 32'h7FC00000, 4'h8}, // R6 signaling NaN
    {4'd6, 32'hFFC00000, 32'h7F800000, 32'h7FC00000, 4'h8}, // R6 NaN times inf
    {4'd7, 32'h00000000, 32'h7F800000, 32'h7FC00000, 4'h8}, // R7
    {4'd7, 32'hFF800000, 32'h80000000, 32'h7FC00000, 4'h8}, // R7 swapped order
    {4'd7, 32'h00400000, 32'h7F800000, 32'h7FC00000, 4'h8}, // R7 subnormal as zero
    {4'd8, 32'h7F800000, 32'hC0000000, 32'hFF800000, 4'h0}, // R8
    {4'd8, 32'h7F800000, 32'h7F800000, 32'h7F800000, 4'h0}, // R8 inf*inf
    {4'd8, 32'h00800000, 32'hFF800000, 32'hFF800000, 4'h0}, // R8 tiny normal * inf
    {4'd9, 32'h80000000, 32'h3F800000, 32'h80000000, 4'h0}, // R9
    {4'd9, 32'h00000001, 32'h40000000, 32'h00000000, 4'h0}, // R9 subnormal flush
    {4'd9, 32'h7F7FFFFF, 32'h00000000, 32'h00000000, 4'h0}, // R9 huge * zero
    {4'd9, 32'h807FFFFF, 32'h3F800000, 32'h80000000, 4'h0}  // R9 negative subnormal
  };

  task automatic check(input logic ok, input string req, input string what,
                       input logic [35:0] actual, input logic [35:0] expected);
    checkCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, actual, expected);
    end
  endtask

  function automatic logic [3:0] flagVec();
    return {flagInvalid, flagOverflow, flagUnderflow, flagInexact};
  endfunction

  task automatic runOne(input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] expRes, input logic [3:0] expFlg,
                        input string req);
    @(negedge clk);
    start = 1'b1; opA = a; opB = b;
    @(negedge clk);
    start = 1'b0;
    check(resValid == 1'b0, "R1", "valid early (1)", 36'(resValid), 36'd0);
    @(negedge clk);
    check(resValid == 1'b0, "R1", "valid early (2)", 36'(resValid), 36'd0);
    @(negedge clk);
    check(resValid == 1'b1, "R1", "valid at latency", 36'(resValid), 36'd1);
    check(result == expRes && flagVec() == expFlg, req, $sformatf("%h*%h", a, b),
          {result, flagVec()}, {expRes, expFlg});
  endtask

  task automatic finish();
    $display("  CHECKS %0d ERRORS %0d", checkCount, errCount);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errCount++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check(!resValid && result == '0 && flagVec() == 4'h0, "R10", "reset outputs",
          {result, flagVec()}, 36'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      runOne(VEC[i][99:68], VEC[i][67:36], VEC[i][35:4], VEC[i][3:0],
             $sformatf("R%0d", VEC[i][103:100]));
    end

    // R1 back-to-back issue: three starts on consecutive cycles
    @(negedge clk);
    start = 1'b1; opA = 32'h40000000; opB = 32'h40000000; // 4.0
    @(negedge clk);
    opA = 32'h40400000; opB = 32'h40400000;                // 9.0
    @(negedge clk);
    opA = 32'h7F000000; opB = 32'h40000000;                // overflow
    @(negedge clk);
    start = 1'b0;
    check(resValid && result == 32'h40800000, "R1", "pipelined #1",
          {result, flagVec()}, {32'h40800000, 4'h0});
    @(negedge clk);
    check(resValid && result == 32'h41100000, "R1", "pipelined #2",
          {result, flagVec()}, {32'h41100000, 4'h0});
    @(negedge clk);
    check(resValid && result == 32'h7F800000 && flagVec() == 4'h5, "R1", "pipelined #3",
          {result, flagVec()}, {32'h7F800000, 4'h5});
    @(negedge clk);
    check(resValid == 1'b0, "R1", "valid after burst", 36'(resValid), 36'd0);
    // outputs hold after completion
    check(result == 32'h7F800000, "R1", "result held", 36'(result), 36'h7F800000);

    // R10 reset with a product in flight
    @(negedge clk);
    start = 1'b1; opA = 32'h3F800000; opB = 32'h40000000;
    @(negedge clk);
    start = 1'b0;
    rstN  = 1'b0;
    @(negedge clk);
    check(!resValid && result == '0 && flagVec() == 4'h0, "R10", "outputs in reset",
          {result, flagVec()}, 36'd0);
    rstN = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(resValid == 1'b0, "R10", "flushed product stays silent", 36'(resValid), 36'd0);
    end

    finish();
  end
endmodule